// File: doc/BRIEF.md
# Read-Order Monitor for a Single Memory Location

This block is a synthesizable observer that sits beside a memory system under test and watches one location. A writer stores the value 0 and then the value 1 into that location. A reader keeps reading it. External capture strobes pick which of those reads count as sample points. The monitor latches the picked values in program order and then judges whether the reader ever saw the location move backwards.

Two judgements are available, chosen by a mode input. The two-sample check demands that the second sample is never below the first. The three-sample check demands that when the first and third samples agree, the middle one agrees with them too, so a value that was overwritten never comes back. An optional barrier mode accepts a sample only when a read-read barrier strobe comes with that read.

The verdict is a sticky error flag with a failure code and a done flag, and a synchronous clear starts a new trial. A separate sticky flag reports a writer that stored 1 before 0. That case is misuse of the test, so it is kept apart from a real ordering fault.

Top module: `rdorder_monitor`

## Requirements
- R1: After reset, `done`, `err_order`, `err_stim` and `fail_code` are all zero.
- R2: A sample is latched only on a cycle with both `rd_valid` and `cap_strobe` high. A strobe without `rd_valid` is ignored, and so is a read without a strobe.
- R3: With `mode_three`=0, `done` rises on the edge that latches the second sample. On that same edge `err_order` is set with `fail_code`=2'b01 if the second sample is numerically below the first. Otherwise no error is set.
- R4: With `mode_three`=1, `done` rises on the edge that latches the third sample and not earlier. On that edge `err_order` is set with `fail_code`=2'b10 when the first and third samples are equal and the middle one differs.
- R5: With `barrier_mode`=1, a sample is latched only if `rr_barrier` is high in the same cycle. Barrier pulses that carry no sampled read have no effect on the verdict.
- R6: Once `done` is high, further strobes and reads latch nothing and leave the verdict unchanged.
- R7: `done`, `err_order`, `fail_code` and `err_stim` hold their values until `clr` is high on a clock edge. That edge returns all of them and the capture sequence to the reset state.
- R8: A write of 1 that happens before any write of 0 since the last reset or clear sets `err_stim` on the write's edge and does not touch `err_order`. The order 0 then 1 raises nothing.
- R9: The capture sequence only moves forward, and `done` stays high until a clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr | input | 1 | Synchronous clear that starts a new trial |
| mode_three | input | 1 | 0: two-sample check, 1: three-sample check |
| barrier_mode | input | 1 | 1: a sample needs `rr_barrier` |
| wr_valid | input | 1 | Writer stores to the location this cycle |
| wr_data | input | DATA_W | Value being stored |
| rd_valid | input | 1 | Reader returns a value this cycle |
| rd_data | input | DATA_W | Value returned by the read |
| cap_strobe | input | 1 | Selects this read as a sample point |
| rr_barrier | input | 1 | Read-read barrier accompanies this read |
| done | output | 1 | Verdict available |
| err_order | output | 1 | Sticky ordering violation |
| fail_code | output | 2 | 01: value decreased, 10: old value returned |
| err_stim | output | 1 | Sticky writer protocol violation |

## Verification
Every result is registered once. The verdict (`done`, `err_order`, `fail_code`) is visible right after the clock edge that latches the final sample. `err_stim` is visible after the edge that samples the offending write, and a clear takes effect on its own edge. The bench drives each stimulus at a falling edge and queues the expected outputs just after the next rising edge. A monitor then compares them at the following falling edge, so each comparison lands one half-cycle after the register that produces it. Interim checks after a non-final sample confirm that `done` has not risen early.

// File: rtl/rdord_pkg.sv
package rdord_pkg;
   typedef enum logic [1:0] {
      CAP_S0   = 2'd0,
      CAP_S1   = 2'd1,
      CAP_S2   = 2'd2,
      CAP_DONE = 2'd3
   } cap_state_e;

   localparam int unsigned SLOTS = 3;

   localparam logic [1:0] FAIL_NONE     = 2'b00;
   localparam logic [1:0] FAIL_DECREASE = 2'b01;
   localparam logic [1:0] FAIL_RETURN   = 2'b10;
endpackage

// File: rtl/rdord_capture_seq.sv
module rdord_capture_seq
   import rdord_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             mode_three,
   input  logic             barrier_mode,
   input  logic             rd_valid,
   input  logic             cap_strobe,
   input  logic             rr_barrier,
   output logic [SLOTS-1:0] slot_we,
   output logic             final_take,
   output logic             done
);
   cap_state_e state_q, state_d;
   logic       take;

   assign take = rd_valid && cap_strobe && (!barrier_mode || rr_barrier)
                 && (state_q != CAP_DONE);

   always_comb begin
      for (int i = 0; i < SLOTS; i++) begin
         slot_we[i] = take && (state_q == cap_state_e'(i));
      end
   end

   assign final_take = take && ((state_q == CAP_S2) ||
                                (state_q == CAP_S1 && !mode_three));

   always_comb begin
      state_d = state_q;
      if (take) begin
         unique case (state_q)
            CAP_S0:   state_d = CAP_S1;
            CAP_S1:   state_d = mode_three ? CAP_S2 : CAP_DONE;
            CAP_S2:   state_d = CAP_DONE;
            default:  state_d = state_q;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   state_q <= CAP_S0;
      else if (clr) state_q <= CAP_S0;
      else          state_q <= state_d;
   end

   assign done = (state_q == CAP_DONE);

   // R9: no backward step without a clear
   p_state_fwd_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !clr |=> (state_q >= $past(state_q)));
   // R2: at most one slot written per cycle
   p_one_slot_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(slot_we));
   // R6: nothing latched after the verdict
   p_no_take_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (slot_we == '0));
endmodule

// File: rtl/rdord_capture_bank.sv
module rdord_capture_bank
   import rdord_pkg::*;
#(
   parameter int unsigned DATA_W = 1
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         clr,
   input  logic [SLOTS-1:0]             slot_we,
   input  logic [DATA_W-1:0]            rd_data,
   output logic [SLOTS-1:0][DATA_W-1:0] slot_q
);
   for (genvar g = 0; g < SLOTS; g++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)          slot_q[g] <= '0;
         else if (clr)        slot_q[g] <= '0;
         else if (slot_we[g]) slot_q[g] <= rd_data;
      end
   end
endmodule

// File: rtl/rdord_verdict.sv
module rdord_verdict
   import rdord_pkg::*;
#(
   parameter int unsigned DATA_W = 1
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         clr,
   input  logic                         mode_three,
   input  logic                         final_take,
   input  logic [DATA_W-1:0]            rd_data,
   input  logic [SLOTS-1:0][DATA_W-1:0] slot_q,
   output logic                         err_order,
   output logic [1:0]                   fail_code
);
   logic decreased, returned;

   // the final sample is still on rd_data on the edge that latches it
   assign decreased = (rd_data < slot_q[0]);
   assign returned  = (rd_data == slot_q[0]) && (slot_q[1] != slot_q[0]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         err_order <= 1'b0;
         fail_code <= FAIL_NONE;
      end else if (clr) begin
         err_order <= 1'b0;
         fail_code <= FAIL_NONE;
      end else if (final_take) begin
         if (mode_three && returned) begin
            err_order <= 1'b1;
            fail_code <= FAIL_RETURN;
         end else if (!mode_three && decreased) begin
            err_order <= 1'b1;
            fail_code <= FAIL_DECREASE;
         end
      end
   end

   // R7: error stays until cleared
   p_order_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (err_order && !clr) |=> (err_order && $stable(fail_code)));
   // R3: a single failure kind is reported
   p_code_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(fail_code));
   // R3: code present exactly when flagged
   p_code_err_r3: assert property (@(posedge clk) disable iff (!rst_n)
      err_order |-> (fail_code != FAIL_NONE));
endmodule

// File: rtl/rdord_stim_guard.sv
module rdord_stim_guard #(
   parameter int unsigned DATA_W = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              wr_valid,
   input  logic [DATA_W-1:0] wr_data,
   output logic              err_stim
);
   localparam logic [DATA_W-1:0] VAL_ZERO = '0;
   localparam logic [DATA_W-1:0] VAL_ONE  = DATA_W'(1);

   logic seen_zero_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seen_zero_q <= 1'b0;
         err_stim    <= 1'b0;
      end else if (clr) begin
         seen_zero_q <= 1'b0;
         err_stim    <= 1'b0;
      end else if (wr_valid) begin
         if (wr_data == VAL_ZERO) seen_zero_q <= 1'b1;
         if (wr_data == VAL_ONE && !seen_zero_q) err_stim <= 1'b1;
      end
   end

   // R8: protocol error is sticky
   p_stim_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (err_stim && !clr) |=> err_stim);
endmodule

// File: rtl/rdorder_monitor.sv
module rdorder_monitor
   import rdord_pkg::*;
#(
   parameter int unsigned DATA_W = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              mode_three,
   input  logic              barrier_mode,
   input  logic              wr_valid,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_valid,
   input  logic [DATA_W-1:0] rd_data,
   input  logic              cap_strobe,
   input  logic              rr_barrier,
   output logic              done,
   output logic              err_order,
   output logic [1:0]        fail_code,
   output logic              err_stim
);
   if (DATA_W < 1) begin : g_bad_width
      $error("rdorder_monitor: DATA_W must be at least 1");
   end

   logic [SLOTS-1:0]             slot_we;
   logic                         final_take;
   logic [SLOTS-1:0][DATA_W-1:0] slot_q;

   rdord_capture_seq u_seq (
      .clk          (clk),
      .rst_n        (rst_n),
      .clr          (clr),
      .mode_three   (mode_three),
      .barrier_mode (barrier_mode),
      .rd_valid     (rd_valid),
      .cap_strobe   (cap_strobe),
      .rr_barrier   (rr_barrier),
      .slot_we      (slot_we),
      .final_take   (final_take),
      .done         (done)
   );

   rdord_capture_bank #(.DATA_W(DATA_W)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (clr),
      .slot_we (slot_we),
      .rd_data (rd_data),
      .slot_q  (slot_q)
   );

   rdord_verdict #(.DATA_W(DATA_W)) u_verdict (
      .clk        (clk),
      .rst_n      (rst_n),
      .clr        (clr),
      .mode_three (mode_three),
      .final_take (final_take),
      .rd_data    (rd_data),
      .slot_q     (slot_q),
      .err_order  (err_order),
      .fail_code  (fail_code)
   );

   rdord_stim_guard #(.DATA_W(DATA_W)) u_guard (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (clr),
      .wr_valid (wr_valid),
      .wr_data  (wr_data),
      .err_stim (err_stim)
   );

   // R3: a verdict error only once a verdict exists
   p_err_needs_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
      err_order |-> done);
   // R7: clear restores the idle state
   p_clr_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (!done && !err_order && !err_stim));
   // R6: samples frozen after the verdict
   p_cap_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !clr) |=> $stable(slot_q));
   // R9: done held until clear
   p_done_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !clr) |=> done);
endmodule

// File: tb/rdorder_monitor_bench.sv
module rdorder_monitor_bench;
   localparam int unsigned DATA_W = 1;
   localparam time         CLK_PERIOD = 10ns;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              clr = 1'b0;
   logic              mode_three = 1'b0;
   logic              barrier_mode = 1'b0;
   logic              wr_valid = 1'b0;
   logic [DATA_W-1:0] wr_data = '0;
   logic              rd_valid = 1'b0;
   logic [DATA_W-1:0] rd_data = '0;
   logic              cap_strobe = 1'b0;
   logic              rr_barrier = 1'b0;
   logic              done, err_order, err_stim;
   logic [1:0]        fail_code;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   typedef struct {
      bit       done;
      bit       eo;
      bit       es;
      bit [1:0] fc;
      string    tag;
   } exp_t;

   exp_t exp_q[$];
   exp_t cur;

   always #(CLK_PERIOD/2) clk = ~clk;

   rdorder_monitor #(.DATA_W(DATA_W)) u_rdorder_monitor (
      .clk(clk), .rst_n(rst_n), .clr(clr), .mode_three(mode_three),
      .barrier_mode(barrier_mode), .wr_valid(wr_valid), .wr_data(wr_data),
      .rd_valid(rd_valid), .rd_data(rd_data), .cap_strobe(cap_strobe),
      .rr_barrier(rr_barrier), .done(done), .err_order(err_order),
      .fail_code(fail_code), .err_stim(err_stim)
   );

   // monitor: compares queued expectations half a cycle after each edge
   always @(negedge clk) begin
      if (exp_q.size() > 0) begin
         cur = exp_q.pop_front();
         checks++;
         if (done !== cur.done || err_order !== cur.eo ||
             err_stim !== cur.es || fail_code !== cur.fc) begin
            errors++;
            $display("FAIL %s: actual done=%0b err_order=%0b err_stim=%0b fail_code=%b, expected done=%0b err_order=%0b err_stim=%0b fail_code=%b",
                     cur.tag, done, err_order, err_stim, fail_code,
                     cur.done, cur.eo, cur.es, cur.fc);
         end
      end
   end

   task automatic step(input bit rv, input bit [DATA_W-1:0] rd, input bit cs,
                       input bit bar, input bit wv, input bit [DATA_W-1:0] wd);
      @(negedge clk);
      clr = 1'b0; rd_valid = rv; rd_data = rd; cap_strobe = cs;
      rr_barrier = bar; wr_valid = wv; wr_data = wd;
      @(posedge clk);
   endtask

   task automatic cap(input bit [DATA_W-1:0] v);
      step(1'b1, v, 1'b1, 1'b1, 1'b0, '0);
   endtask

   task automatic idle();
      step(1'b0, '0, 1'b0, 1'b0, 1'b0, '0);
   endtask

   task automatic do_clr();
      @(negedge clk);
      clr = 1'b1; rd_valid = 1'b0; cap_strobe = 1'b0; rr_barrier = 1'b0;
      wr_valid = 1'b0;
      @(posedge clk);
   endtask

   // driver side: queue the values due after the edge just taken
   task automatic expect_out(input bit d, input bit eo, input bit es,
                             input bit [1:0] fc, input string tag);
      exp_t e;
      #1;
      e.done = d; e.eo = eo; e.es = es; e.fc = fc; e.tag = tag;
      exp_q.push_back(e);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual hung run, expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(posedge clk);
      expect_out(0, 0, 0, 2'b00, "R1 reset state");

      // two-sample mode, rising sequence
      step(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, '0);   // strobe with no read
      cap(1'b0);
      expect_out(0, 0, 0, 2'b00, "R2 strobe without read ignored");
      step(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, '0);   // read without strobe
      expect_out(0, 0, 0, 2'b00, "R2 read without strobe ignored");
      cap(1'b1);
      expect_out(1, 0, 0, 2'b00, "R3 rising pair passes");
      cap(1'b0);
      expect_out(1, 0, 0, 2'b00, "R6 R9 strobe after done ignored");

      // falling pair
      do_clr();
      expect_out(0, 0, 0, 2'b00, "R7 clear");
      cap(1'b1);
      cap(1'b0);
      expect_out(1, 1, 0, 2'b01, "R3 falling pair flagged");
      idle();
      expect_out(1, 1, 0, 2'b01, "R7 error sticky");
      cap(1'b1);
      cap(1'b1);
      expect_out(1, 1, 0, 2'b01, "R6 verdict unchanged after done");

      // three-sample mode
      mode_three = 1'b1;
      do_clr();
      cap(1'b0);
      cap(1'b1);
      expect_out(0, 0, 0, 2'b00, "R4 no verdict after two samples");
      cap(1'b0);
      expect_out(1, 1, 0, 2'b10, "R4 old value returned");

      do_clr();
      cap(1'b0);
      step(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, '0);   // discarded read
      cap(1'b0);
      cap(1'b0);
      expect_out(1, 0, 0, 2'b00, "R2 R4 uncaptured read discarded");

      do_clr();
      cap(1'b0); cap(1'b0); cap(1'b1);
      expect_out(1, 0, 0, 2'b00, "R4 0,0,1 passes");
      do_clr();
      cap(1'b1); cap(1'b1); cap(1'b1);
      expect_out(1, 0, 0, 2'b00, "R4 1,1,1 passes");
      do_clr();
      cap(1'b0); cap(1'b1); cap(1'b1);
      expect_out(1, 0, 0, 2'b00, "R4 0,1,1 passes");
      do_clr();
      cap(1'b1); cap(1'b0); cap(1'b1);
      expect_out(1, 1, 0, 2'b10, "R4 1,0,1 flagged");

      // barrier-qualified two-sample mode
      mode_three = 1'b0;
      barrier_mode = 1'b1;
      do_clr();
      step(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, '0);   // strobe without barrier
      expect_out(0, 0, 0, 2'b00, "R5 unbarriered sample ignored");
      step(1'b1, 1'b1, 1'b1, 1'b1, 1'b0, '0);
      expect_out(0, 0, 0, 2'b00, "R5 first barriered sample");
      step(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, '0);   // lone barriers
      step(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, '0);
      step(1'b1, 1'b1, 1'b0, 1'b1, 1'b0, '0);
      step(1'b1, 1'b0, 1'b1, 1'b1, 1'b0, '0);
      expect_out(1, 1, 0, 2'b01, "R5 barriered falling pair flagged");

      // writer protocol
      barrier_mode = 1'b0;
      do_clr();
      step(1'b0, '0, 1'b0, 1'b0, 1'b1, 1'b1);
      expect_out(0, 0, 1, 2'b00, "R8 write 1 before 0 flagged");
      idle();
      expect_out(0, 0, 1, 2'b00, "R7 R8 protocol error sticky");
      do_clr();
      expect_out(0, 0, 0, 2'b00, "R7 clear drops protocol error");
      step(1'b0, '0, 1'b0, 1'b0, 1'b1, 1'b0);
      step(1'b0, '0, 1'b0, 1'b0, 1'b1, 1'b1);
      expect_out(0, 0, 0, 2'b00, "R8 0 then 1 accepted");

      idle();
      idle();
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule